// File: doc/BRIEF.md
# Bus-Attached Successive-Approximation Converter Sequencer

This block is the digital half of a successive-approximation converter that hangs off a microprocessor bus. A processor starts a conversion by pulsing the chip enable while the part is selected and the read/convert line is low. It can ask for a full 12-bit result or a faster 8-bit result. The block then puts out a busy flag. After a fixed number of setup clocks it runs one SAR trial per clock: it presents a trial code to the external DAC and keeps or clears each bit according to a comparator input.

Once the result is ready, the processor reads it back through the same strobes with read/convert high. A format pin picks between one 12-bit word and two 8-bit slices chosen by the address bit. The tri-state data bus is modelled as a data word plus an enable. A start condition that arrives while a conversion is running neither aborts nor restarts it. It does, however, re-latch the length-select address bit, so the conversion in progress can end at a different length than the one requested.

Top module: `adc_bus_ctrl`

## Requirements
- R1: While the block is idle, a rising edge of the start condition (`chip_en`=1, `sel_n`=0, `rd_cnv`=0), seen at a clock edge, sets `busy` high from that edge on.
- R2: `busy` stays high for exactly SETUP_CYC+12 clocks when `addr_lo` was 0 at the start (full length), and for SETUP_CYC+8 clocks when it was 1 (short length). With the defaults this is 14 and 10 clocks. `busy` is low at all other times.
- R3: While `busy` is high, `rd_en` is 0, so no read is possible.
- R4: A start condition during a conversion does not abort or restart it. When `addr_lo` is unchanged, the length and the result are unaffected.
- R5: `rd_en` is 1 only when `rd_cnv`=1, `busy`=0, `chip_en`=1 and `sel_n`=0 all hold together.
- R6: While `rd_en` is 0, `rd_data` is all zeros. This stands for the high-impedance bus.
- R7: On a read, `wide_rd`=1 drives the whole 12-bit result. `wide_rd`=0 with `addr_lo`=0 drives result bits 11:4 on `rd_data[11:4]` with zeros below. `wide_rd`=0 with `addr_lo`=1 drives result bits 3:0 on `rd_data[11:8]` with zeros below.
- R8: The SAR decides bits from the MSB down. A `cmp_hi` of 1 keeps the trial bit and 0 clears it. After a full conversion the result equals the input code the comparator tracks. After a short conversion the upper 8 bits are decided this way and the four LSBs read as zero.
- R9: Each start condition during a conversion re-latches `addr_lo`. Changing it from 0 to 1 before bit 4 is decided ends the conversion after bit 4, with a short-length result. Changing it from 1 to 0 extends the conversion to all 12 bits.
- R10: After synchronous reset, `busy`=0, `rd_en`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Active-high bus strobe |
| sel_n | input | 1 | Active-low select |
| rd_cnv | input | 1 | 1 = read access, 0 = convert request |
| addr_lo | input | 1 | Length select at start; slice select on reads |
| wide_rd | input | 1 | 1 = 12-bit read, 0 = 8-bit slice reads |
| cmp_hi | input | 1 | Comparator result: trial code not above input |
| busy | output | 1 | High while a conversion runs |
| trial_code | output | 12 | Current SAR code to the DAC |
| rd_data | output | 12 | Read data, zeros when not enabled |
| rd_en | output | 1 | Read data drive enable |

## Verification
On every cycle, the bound checker checks that the read enable never coexists with `busy` and appears only under the four-way strobe condition. It also checks that undriven data is zero, that slice reads keep the low nibble clear, that a fresh start while idle raises `busy`, and that no conversion runs longer than the full length. The exact busy lengths, the SAR result against a modelled comparator, the slice placement, and the effect of a mid-conversion re-latch of the length bit in either direction depend on whole sequences. Only the bench scenarios show these.

// File: rtl/adcctl_pkg.sv
package adcctl_pkg;
    localparam int DEF_RES_W     = 12;
    localparam int DEF_SHORT_W   = 8;
    localparam int DEF_SETUP_CYC = 2;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_STEP  = 2'd2
    } phase_e;

    typedef struct packed {
        logic strobe;
        logic sel_n;
        logic read;
    } bus_ctl_t;

    function automatic logic go_req(input bus_ctl_t b);
        return b.strobe && !b.sel_n && !b.read;
    endfunction

    function automatic logic rd_req(input bus_ctl_t b);
        return b.strobe && !b.sel_n && b.read;
    endfunction
endpackage

// File: rtl/adcctl_bus_decode.sv
module adcctl_bus_decode
    import adcctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_ctl_t bus,
    input  logic     busy,
    output logic     start_pulse,
    output logic     read_ok
);
    logic go_now;
    logic go_q;

    assign go_now = go_req(bus);

    always_ff @(posedge clk) begin
        if (rst) go_q <= 1'b0;
        else     go_q <= go_now;
    end

    assign start_pulse = go_now && !go_q;
    assign read_ok     = rd_req(bus) && !busy;
endmodule

// File: rtl/adcctl_sar_seq.sv
module adcctl_sar_seq
    import adcctl_pkg::*;
#(
    parameter int RES_W     = DEF_RES_W,
    parameter int SHORT_W   = DEF_SHORT_W,
    parameter int SETUP_CYC = DEF_SETUP_CYC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_pulse,
    input  logic             len_sel,
    input  logic             cmp_hi,
    output logic             busy,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] result
);
    localparam int LOW_W = RES_W - SHORT_W;
    localparam int IDX_W = $clog2(RES_W);
    localparam int CNT_W = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

    phase_e             phase_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [IDX_W-1:0]   idx_q;
    logic [RES_W-1:0]   sar_q;
    logic [RES_W-1:0]   sar_nxt;
    logic [RES_W-1:0]   res_q;
    logic               short_q;
    logic               busy_q;
    logic               last;

    assign last = (idx_q == '0) || (short_q && (idx_q <= IDX_W'(LOW_W)));

    always_comb begin
        sar_nxt        = sar_q;
        sar_nxt[idx_q] = cmp_hi;
        if (!last) sar_nxt[idx_q - IDX_W'(1)] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sar_q   <= '0;
            res_q   <= '0;
            short_q <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            if (start_pulse) short_q <= len_sel;
            case (phase_q)
                PH_IDLE: begin
                    if (start_pulse) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= '0;
                        idx_q   <= IDX_W'(RES_W - 1);
                        sar_q   <= {1'b1, {(RES_W-1){1'b0}}};
                        busy_q  <= 1'b1;
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == CNT_W'(SETUP_CYC - 1)) phase_q <= PH_STEP;
                    else                                cnt_q   <= cnt_q + CNT_W'(1);
                end
                PH_STEP: begin
                    sar_q <= sar_nxt;
                    if (last) begin
                        res_q   <= short_q ? {sar_nxt[RES_W-1:LOW_W], {LOW_W{1'b0}}}
                                           : sar_nxt;
                        phase_q <= PH_IDLE;
                        busy_q  <= 1'b0;
                    end else begin
                        idx_q <= idx_q - IDX_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy   = busy_q;
    assign trial  = sar_q;
    assign result = res_q;
endmodule

// File: rtl/adcctl_out_sel.sv
module adcctl_out_sel #(
    parameter int RES_W   = 12,
    parameter int SHORT_W = 8
) (
    input  logic [RES_W-1:0] result,
    input  logic             enable,
    input  logic             wide,
    input  logic             slice_lo,
    output logic [RES_W-1:0] data,
    output logic             data_en
);
    localparam int LOW_W = RES_W - SHORT_W;

    logic [RES_W-1:0] hi_slice;
    logic [RES_W-1:0] lo_slice;

    assign hi_slice = {result[RES_W-1:LOW_W], {LOW_W{1'b0}}};
    assign lo_slice = {result[LOW_W-1:0], {SHORT_W{1'b0}}};

    always_comb begin
        data = '0;
        if (enable) begin
            if (wide)          data = result;
            else if (slice_lo) data = lo_slice;
            else               data = hi_slice;
        end
    end

    assign data_en = enable;
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
    import adcctl_pkg::*;
#(
    parameter int RES_W     = DEF_RES_W,
    parameter int SHORT_W   = DEF_SHORT_W,
    parameter int SETUP_CYC = DEF_SETUP_CYC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chip_en,
    input  logic             sel_n,
    input  logic             rd_cnv,
    input  logic             addr_lo,
    input  logic             wide_rd,
    input  logic             cmp_hi,
    output logic             busy,
    output logic [RES_W-1:0] trial_code,
    output logic [RES_W-1:0] rd_data,
    output logic             rd_en
);
    bus_ctl_t         bus;
    logic             start_pulse;
    logic             read_ok;
    logic [RES_W-1:0] result;

    assign bus = '{strobe: chip_en, sel_n: sel_n, read: rd_cnv};

    adcctl_bus_decode u_dec (
        .clk         (clk),
        .rst         (rst),
        .bus         (bus),
        .busy        (busy),
        .start_pulse (start_pulse),
        .read_ok     (read_ok)
    );

    adcctl_sar_seq #(
        .RES_W     (RES_W),
        .SHORT_W   (SHORT_W),
        .SETUP_CYC (SETUP_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_pulse (start_pulse),
        .len_sel     (addr_lo),
        .cmp_hi      (cmp_hi),
        .busy        (busy),
        .trial       (trial_code),
        .result      (result)
    );

    adcctl_out_sel #(
        .RES_W   (RES_W),
        .SHORT_W (SHORT_W)
    ) u_out (
        .result   (result),
        .enable   (read_ok),
        .wide     (wide_rd),
        .slice_lo (addr_lo),
        .data     (rd_data),
        .data_en  (rd_en)
    );
endmodule

// File: rtl/adcctl_chk.sv
module adcctl_chk #(
    parameter int RES_W     = 12,
    parameter int SHORT_W   = 8,
    parameter int SETUP_CYC = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             chip_en,
    input logic             sel_n,
    input logic             rd_cnv,
    input logic             wide_rd,
    input logic             busy,
    input logic [RES_W-1:0] rd_data,
    input logic             rd_en
);
    localparam int LOW_W = RES_W - SHORT_W;

    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_len <= '0;
        else              run_len <= run_len + 16'd1;
    end

    AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !busy); // R3

    AST_READ_STROBES: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (chip_en && !sel_n && rd_cnv)); // R5

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0)); // R6

    AST_SLICE_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wide_rd) |-> (rd_data[LOW_W-1:0] == '0)); // R7

    AST_START_RISE: assert property (@(posedge clk) disable iff (rst)
        (!busy && chip_en && !sel_n && !rd_cnv && !$past(chip_en && !sel_n && !rd_cnv))
        |=> busy); // R1

    AST_MAX_LEN: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < 16'(SETUP_CYC + RES_W))); // R2

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !rd_en)); // R10
endmodule

bind adc_bus_ctrl adcctl_chk #(
    .RES_W     (RES_W),
    .SHORT_W   (SHORT_W),
    .SETUP_CYC (SETUP_CYC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .chip_en (chip_en),
    .sel_n   (sel_n),
    .rd_cnv  (rd_cnv),
    .wide_rd (wide_rd),
    .busy    (busy),
    .rd_data (rd_data),
    .rd_en   (rd_en)
);

// File: tb/tb_adc_bus_ctrl.sv
`timescale 1ns/1ps
module tb_adc_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chip_en = 1'b0;
    logic        sel_n = 1'b1;
    logic        rd_cnv = 1'b1;
    logic        addr_lo = 1'b0;
    logic        wide_rd = 1'b1;
    logic        cmp_hi;
    logic        busy;
    logic [11:0] trial_code;
    logic [11:0] rd_data;
    logic        rd_en;
    logic [11:0] vin = 12'h000;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign cmp_hi = (trial_code <= vin);

    adc_bus_ctrl dut (
        .clk(clk), .rst(rst), .chip_en(chip_en), .sel_n(sel_n),
        .rd_cnv(rd_cnv), .addr_lo(addr_lo), .wide_rd(wide_rd),
        .cmp_hi(cmp_hi), .busy(busy), .trial_code(trial_code),
        .rd_data(rd_data), .rd_en(rd_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic ce_v, input logic seln_v, input logic wide_v,
                           input logic a_v, output logic oe, output logic [11:0] d);
        chip_en = 1'b0;
        rd_cnv  = 1'b1;
        sel_n   = seln_v;
        wide_rd = wide_v;
        addr_lo = a_v;
        chip_en = ce_v;
        #1;
        oe = rd_en;
        d  = rd_data;
        chip_en = 1'b0;
        sel_n   = 1'b1;
    endtask

    task automatic run_conv(input logic [11:0] v, input logic a_v, input int inj_at,
                            input logic inj_a, input int exp_len, input logic [11:0] exp_res,
                            input string tag);
        int cnt;
        logic oe;
        logic [11:0] d;
        vin = v;
        @(negedge clk);
        chip_en = 1'b1; sel_n = 1'b0; rd_cnv = 1'b0; addr_lo = a_v;
        @(negedge clk);
        chip_en = 1'b0;
        check({tag, " R1 busy after start"}, int'(busy), 1);
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            if (cnt == inj_at) begin
                rd_cnv = 1'b0; sel_n = 1'b0; addr_lo = inj_a; chip_en = 1'b1;
            end else begin
                chip_en = 1'b0;
            end
            if (cnt == 6) begin
                chip_en = 1'b0; rd_cnv = 1'b1; sel_n = 1'b0; chip_en = 1'b1;
                #1;
                check({tag, " R3 no read while busy"}, int'(rd_en), 0);
                check({tag, " R6 data zero while busy"}, int'(rd_data), 0);
                chip_en = 1'b0; rd_cnv = 1'b0;
            end
            @(negedge clk);
        end
        chip_en = 1'b0;
        check({tag, " R2/R4/R9 busy length"}, cnt, exp_len);
        do_read(1'b1, 1'b0, 1'b1, 1'b0, oe, d);
        check({tag, " R5 read enabled"}, int'(oe), 1);
        check({tag, " R8 result"}, int'(d), int'(exp_res));
    endtask

    task automatic t_reset();
        check("R10 busy after reset", int'(busy), 0);
        check("R10 rd_en after reset", int'(rd_en), 0);
        check("R10 rd_data after reset", int'(rd_data), 0);
    endtask

    task automatic t_full();
        run_conv(12'hA5C, 1'b0, 0, 1'b0, 14, 12'hA5C, "full");
        run_conv(12'hFFF, 1'b0, 0, 1'b0, 14, 12'hFFF, "full max");
        run_conv(12'h000, 1'b0, 0, 1'b0, 14, 12'h000, "full zero");
    endtask

    task automatic t_short();
        run_conv(12'h3E7, 1'b1, 0, 1'b0, 10, 12'h3E0, "short");
    endtask

    task automatic t_slices();
        logic oe;
        logic [11:0] d;
        run_conv(12'hA5C, 1'b0, 0, 1'b0, 14, 12'hA5C, "slice prep");
        do_read(1'b1, 1'b0, 1'b0, 1'b0, oe, d);
        check("R7 upper slice", int'(d), 12'hA50);
        do_read(1'b1, 1'b0, 1'b0, 1'b1, oe, d);
        check("R7 lower slice", int'(d), 12'hC00);
        do_read(1'b0, 1'b0, 1'b1, 1'b0, oe, d);
        check("R5 strobe low disables", int'(oe), 0);
        check("R6 strobe low data zero", int'(d), 0);
        do_read(1'b1, 1'b1, 1'b1, 1'b0, oe, d);
        check("R5 deselected disables", int'(oe), 0);
        check("R6 deselected data zero", int'(d), 0);
    endtask

    task automatic t_spurious();
        run_conv(12'h6B3, 1'b0, 4, 1'b0, 14, 12'h6B3, "R4 spurious full");
        run_conv(12'h6B3, 1'b1, 4, 1'b1, 10, 12'h6B0, "R4 spurious short");
    endtask

    task automatic t_relatch();
        run_conv(12'h9C7, 1'b0, 3, 1'b1, 10, 12'h9C0, "R9 full to short");
        run_conv(12'h9C7, 1'b1, 3, 1'b0, 14, 12'h9C7, "R9 short to full");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full();
        t_short();
        t_slices();
        t_spurious();
        t_relatch();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule